// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial flash memory and decides, for every decoded write-type command, whether it may run. The command decoder hands it one strobe per completed command (issued when chip select returns high on a byte boundary), together with a 3-bit operation code, the 20-bit target address and, for a status write, the new status byte. The guard answers one cycle later with an accept or reject pulse and, for accepted operations, starts a self-timed busy interval whose length is a parameter counted in system clocks.

Permission rules: the write-enable latch must be set before any status write, program or erase; program and erase targets are checked against a protected region of 64 KB blocks counted down from the top of memory; whole-chip erase needs an empty protected region; and a set lock bit combined with a low write-protect pin freezes the status register. While busy, every command strobe is refused, so the decoder can use the busy output to suppress identification and fast-read commands and array accesses. When a busy interval ends, the write-enable latch is cleared in the same cycle.

Top module: `flash_status_guard`

## Requirements
- R1: After power-on reset the status byte is 8'h00, the busy output is 0 and neither accept nor reject pulses.
- R2: The status byte holds the lock bit at bit 7, zeros at bits 6 and 5, the three-bit protect level at bits 4..2 (bit 4 most significant), the write-enable latch at bit 1 and the in-progress flag at bit 0; the in-progress flag always equals the busy output.
- R3: Operation codes are 1 enable-write, 2 disable-write, 3 status write, 4 page program, 5 sector erase (4 KB), 6 block erase (64 KB), 7 chip erase; code 0 does nothing. Enable-write sets the write-enable latch and disable-write clears it, visible with an accept pulse in the cycle after the strobe.
- R4: Codes 3 to 7 are rejected when the write-enable latch is 0, and a rejected command changes no status bit.
- R5: An accepted status write copies data bits 7 and 4..2 into the lock bit and the protect level and ignores data bits 6, 5, 1 and 0.
- R6: When the lock bit is 1 and the write-protect input is low, a status write is rejected even with the latch set; with the pin high again it is accepted.
- R7: Program and the erases address block A[19:16]; protect level 0 protects nothing, 1 block 15, 2 blocks 14-15, 3 blocks 12-15, 4 blocks 8-15, and 5 to 7 all blocks; an aimed-at protected block is rejected.
- R8: Chip erase is accepted only when the protect level is 0.
- R9: An accepted operation raises the in-progress flag in the cycle after the strobe and holds it for exactly its parameter's number of cycles; the flag and the write-enable latch fall together.
- R10: While busy, every command strobe with a nonzero code is rejected and changes no status bit.
- R11: A rejected program or erase leaves the write-enable latch as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cmd_vld_i | input | 1 | One-cycle strobe for a completed command |
| cmd_i | input | 3 | Operation code (see R3) |
| addr_i | input | ADDR_W | Target address of program or erase |
| sr_data_i | input | 8 | New status byte for a status write |
| status_o | output | 8 | Status byte (see R2) |
| accept_o | output | 1 | Pulse: previous strobe accepted |
| reject_o | output | 1 | Pulse: previous strobe rejected |
| busy_o | output | 1 | Self-timed operation in progress |

## Verification
Every result is due one clock edge after the strobe: the accept or reject pulse, the latch change, the copied status bits and the rise of the in-progress flag all come from a single register stage. The bench drives the strobe on a falling edge, removes it on the next falling edge and samples there, half a cycle after the edge that registered it. For the busy interval it then counts the parameter's length minus one further falling edges, expects the flag still high, and one edge later expects both flag and latch low.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W = 20,
  parameter int BLK_W  = 4,
  parameter int T_WRSR = 8,
  parameter int T_PROG = 12,
  parameter int T_SECT = 20,
  parameter int T_BLK  = 30,
  parameter int T_CHIP = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n_i,
  input  logic              cmd_vld_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_data_i,
  output logic [7:0]        status_o,
  output logic              accept_o,
  output logic              reject_o,
  output logic              busy_o
);
  localparam int M1 = (T_WRSR > T_PROG) ? T_WRSR : T_PROG;
  localparam int M2 = (T_SECT > T_BLK) ? T_SECT : T_BLK;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int T_MAX = (M3 > T_CHIP) ? M3 : T_CHIP;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int NBLK = 1 << BLK_W;

  localparam logic [2:0] OP_WEN  = 3'd1;
  localparam logic [2:0] OP_WDIS = 3'd2;
  localparam logic [2:0] OP_WSR  = 3'd3;
  localparam logic [2:0] OP_PROG = 3'd4;
  localparam logic [2:0] OP_SECT = 3'd5;
  localparam logic [2:0] OP_BLK  = 3'd6;
  localparam logic [2:0] OP_CHIP = 3'd7;

  logic             lock_q;
  logic [2:0]       lvl_q;
  logic             wel_q;
  logic             wip_q;
  logic [CNT_W-1:0] cnt_q;

  logic             prot_hit;
  logic             ok;
  logic [CNT_W-1:0] len;

  wire [BLK_W-1:0] blk = addr_i[ADDR_W-1 -: BLK_W];
  wire hw_lock = lock_q & ~wp_n_i;
  wire strobe  = cmd_vld_i & (cmd_i != 3'd0);
  wire acc     = strobe & ~wip_q & ok;

  always_comb begin
    case (lvl_q)
      3'd0:    prot_hit = 1'b0;
      3'd1:    prot_hit = blk >= BLK_W'(NBLK - 1);
      3'd2:    prot_hit = blk >= BLK_W'(NBLK - 2);
      3'd3:    prot_hit = blk >= BLK_W'(NBLK - 4);
      3'd4:    prot_hit = blk >= BLK_W'(NBLK / 2);
      default: prot_hit = 1'b1;
    endcase
  end

  always_comb begin
    ok  = 1'b0;
    len = CNT_W'(T_WRSR - 1);
    case (cmd_i)
      OP_WEN, OP_WDIS: ok = 1'b1;
      OP_WSR:  begin ok = wel_q & ~hw_lock;    len = CNT_W'(T_WRSR - 1); end
      OP_PROG: begin ok = wel_q & ~prot_hit;   len = CNT_W'(T_PROG - 1); end
      OP_SECT: begin ok = wel_q & ~prot_hit;   len = CNT_W'(T_SECT - 1); end
      OP_BLK:  begin ok = wel_q & ~prot_hit;   len = CNT_W'(T_BLK - 1);  end
      OP_CHIP: begin ok = wel_q & (lvl_q == 3'd0); len = CNT_W'(T_CHIP - 1); end
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      lvl_q    <= 3'd0;
      wel_q    <= 1'b0;
      wip_q    <= 1'b0;
      cnt_q    <= '0;
      accept_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      accept_o <= acc;
      reject_o <= strobe & ~acc;
      if (wip_q) begin
        if (cnt_q == '0) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (acc) begin
        case (cmd_i)
          OP_WEN:  wel_q <= 1'b1;
          OP_WDIS: wel_q <= 1'b0;
          default: begin
            wip_q <= 1'b1;
            cnt_q <= len;
            if (cmd_i == OP_WSR) begin
              lock_q <= sr_data_i[7];
              lvl_q  <= sr_data_i[4:2];
            end
          end
        endcase
      end
    end
  end

  assign status_o = {lock_q, 2'b00, lvl_q, wel_q, wip_q};
  assign busy_o   = wip_q;

  assert_start_needs_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip_q) |-> $past(wel_q));

  assert_end_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip_q) |-> !wel_q);

  assert_hw_lock_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !wp_n_i) |=> ($stable(lock_q) && $stable(lvl_q)));

  assert_busy_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wip_q && cmd_vld_i && cmd_i != 3'd0) |=> (reject_o && !accept_o));

  assert_chip_needs_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && cmd_i == OP_CHIP && lvl_q != 3'd0) |=> !accept_o);

  assert_single_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && reject_o));
endmodule

// File: tb/test_flash_status_guard.sv
module test_flash_status_guard;
  localparam int TW = 8, TP = 12, TS = 20, TB = 30, TC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1;
  logic vld = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [19:0] addr = '0;
  logic [7:0] sdat = '0;
  logic [7:0] status;
  logic acc, rej, busy;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_status_guard #(.ADDR_W(20), .BLK_W(4), .T_WRSR(TW), .T_PROG(TP),
    .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)) i_flash_status_guard (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .cmd_vld_i(vld), .cmd_i(cmd),
    .addr_i(addr), .sr_data_i(sdat), .status_o(status), .accept_o(acc),
    .reject_o(rej), .busy_o(busy));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    vld = 1'b1; cmd = c; addr = a; sdat = d;
    @(negedge clk);
    vld = 1'b0; cmd = 3'd0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic set_level(input logic [2:0] lv);
    issue(3'd1, '0, '0);
    issue(3'd3, '0, {3'b000, lv, 2'b00});
    wait_idle();
  endtask

  function automatic bit exp_prot(input int lv, input int b);
    case (lv)
      0: return 1'b0;
      1: return b == 15;
      2: return b >= 14;
      3: return b >= 12;
      4: return b >= 8;
      default: return 1'b1;
    endcase
  endfunction

  task automatic t_reset();
    check(status == 8'h00, "R1 status after reset", status, 8'h00);
    check(!busy && !acc && !rej, "R1 outputs idle", {busy, acc, rej}, 0);
  endtask

  task automatic t_latch();
    issue(3'd1, '0, '0);
    check(acc && status == 8'h02, "R3 enable sets latch", status, 8'h02);
    issue(3'd2, '0, '0);
    check(acc && status == 8'h00, "R3 disable clears latch", status, 8'h00);
  endtask

  task automatic t_need_wel();
    for (int c = 3; c <= 7; c++) begin
      issue(3'(c), 20'h00100, 8'h9C);
      check(rej && !acc && !busy && status == 8'h00, "R4 no latch rejects", status, 8'h00);
    end
  endtask

  task automatic t_status_write();
    issue(3'd1, '0, '0);
    issue(3'd3, '0, 8'h7F);
    check(acc && status == 8'h1F, "R5 copy bits, R2 layout", status, 8'h1F);
    wait_idle();
    check(status == 8'h1C, "R5 ignored bits stay", status, 8'h1C);
    set_level(3'd0);
    check(status == 8'h00, "R5 level restored", status, 8'h00);
  endtask

  task automatic t_hw_lock();
    issue(3'd1, '0, '0);
    issue(3'd3, '0, 8'h80);
    wait_idle();
    wp_n = 1'b0;
    issue(3'd1, '0, '0);
    issue(3'd3, '0, 8'h00);
    check(rej && status == 8'h82, "R6 locked status write rejected", status, 8'h82);
    wp_n = 1'b1;
    issue(3'd3, '0, 8'h00);
    check(acc && busy, "R6 pin high accepts", busy, 1);
    wait_idle();
    check(status == 8'h00, "R6 unlocked result", status, 8'h00);
  endtask

  task automatic t_protect();
    for (int lv = 0; lv < 8; lv++) begin
      set_level(3'(lv));
      for (int b = 0; b < 16; b++) begin
        logic [2:0] op;
        op = 3'(4 + (b % 3));
        issue(3'd1, '0, '0);
        issue(op, {4'(b), 16'h1234}, '0);
        check(acc == !exp_prot(lv, b), $sformatf("R7 level %0d block %0d", lv, b),
              acc, !exp_prot(lv, b));
        if (acc) wait_idle();
        else issue(3'd2, '0, '0);
      end
    end
    set_level(3'd0);
  endtask

  task automatic t_chip();
    set_level(3'd2);
    issue(3'd1, '0, '0);
    issue(3'd7, '0, '0);
    check(rej && !busy, "R8 chip erase with level 2", acc, 0);
    set_level(3'd0);
    issue(3'd1, '0, '0);
    issue(3'd7, '0, '0);
    check(acc && busy, "R8 chip erase with level 0", acc, 1);
    wait_idle();
  endtask

  task automatic t_timing(input logic [2:0] op, input int len);
    issue(3'd1, '0, '0);
    issue(op, 20'h00000, '0);
    check(busy && status[0] && status[1], "R9 busy starts", status, 8'h03);
    repeat (len - 1) @(negedge clk);
    check(busy, $sformatf("R9 still busy op %0d", op), busy, 1);
    @(negedge clk);
    check(!busy && status == 8'h00, $sformatf("R9 end clears op %0d", op), status, 8'h00);
  endtask

  task automatic t_busy_refuse();
    issue(3'd1, '0, '0);
    issue(3'd4, 20'h00000, '0);
    issue(3'd2, '0, '0);
    check(rej && status[1], "R10 disable refused while busy", status, 8'h03);
    issue(3'd3, '0, 8'h9C);
    check(rej && status[7:2] == 6'd0, "R10 status write refused while busy", status, 8'h03);
    wait_idle();
    check(status == 8'h00, "R10 status after refusal", status, 8'h00);
  endtask

  task automatic t_keep_wel();
    set_level(3'd1);
    issue(3'd1, '0, '0);
    issue(3'd5, 20'hF0000, '0);
    check(rej && status == 8'h06, "R11 latch kept on protected reject", status, 8'h06);
    issue(3'd6, 20'h10000, '0);
    check(acc, "R11 next erase accepted", acc, 1);
    wait_idle();
    set_level(3'd0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_need_wel();
    t_status_write();
    t_hw_lock();
    t_protect();
    t_chip();
    t_timing(3'd4, TP);
    t_timing(3'd5, TS);
    t_timing(3'd6, TB);
    t_timing(3'd7, TC);
    t_busy_refuse();
    t_keep_wel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule